// File: doc/BRIEF.md
# Scrambled Program-Memory Verify Port

This block models the programming and read-back side of a one-time-programmable code store. An external programmer presents an address, a data byte and a three-bit mode-select code on static pins, then toggles a program strobe. It can do four things: burn a code byte, read a code byte back, burn a byte of a 64-entry scrambling key, or read one of four fixed identification bytes. Code read-back is never plain. Each returned byte is the bitwise XNOR of the stored code byte with the key byte picked by address bits 5:0. While the key is blank (all ones), the code comes back unchanged. The key itself has no direct read path.

A write takes effect only after a fixed number of strobe pulses while address, data and mode stay unchanged. The cells behave like fuses: a write can only clear bits. A wipe input returns both arrays to all ones.

All interface pins are static levels, so there is no valid/ready exchange and no back-pressure. The output byte and its enable are registered, and they follow the inputs of the previous clock cycle.

Top module: `prom_cipher_port`

## Requirements
- R1: In reset, and until a read mode is applied, dout_oe is 0 and dout is 00h. After reset every code and key cell reads as all ones.
- R2: Mode-select encodings are 011 for program code, 001 for verify code, 111 for program key and 000 for read identification. In the two read modes, dout_oe is 1 one clock cycle later.
- R3: In verify mode, dout equals ~(code[addr] ^ key[addr[5:0]]). Code addresses that share bits 5:0 use the same key byte.
- R4: With a blank key, verify returns the code byte unchanged. A code byte of FFh returns the selected key byte.
- R5: Key programming takes effect only at addresses below 40h. Strobes at any other address in key mode change nothing.
- R6: A write commits on the PULSES-th (default 5) rising edge of prog_strobe. Fewer pulses leave the cell unchanged.
- R7: A change of addr, din or mode_sel between pulses restarts the pulse count from zero.
- R8: A commit stores old AND new, so bits can only go from 1 to 0.
- R9: Read-identification mode returns 58h at 30h and at 31h, ADh at 60h, and the REV parameter at 61h. Every other address returns FFh.
- R10: Any other mode-select code (010, 100, 101, 110) makes dout_oe 0 and dout 00h one cycle later.
- R11: A one-cycle wipe pulse returns every code and key cell to FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| mode_sel | input | 3 | Mode-select code |
| prog_strobe | input | 1 | Program strobe; rising edges are counted |
| wipe | input | 1 | Erase both arrays to all ones |
| dout | output | 8 | Read-back byte |
| dout_oe | output | 1 | Read-back drive enable (0 models a floating bus) |

## Verification
The bench builds the block with ADDR_W=8, PULSES=5 and REV=07h. The 256-byte code space is still wide enough to decode the identification addresses 60h and 61h. It also lets addresses 05h, 45h and 85h alias onto the same key byte, which brings both the key-address limit and key sharing across the code space within reach. The revision value differs from the default, so a byte that is hard-wired instead of taken from the parameter shows up in the checks.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic [2:0] {
    MODE_SIG       = 3'b000,
    MODE_VERIFY    = 3'b001,
    MODE_PROG_CODE = 3'b011,
    MODE_PROG_KEY  = 3'b111
  } prom_mode_e;

  localparam int KEY_AW = 6;
  localparam logic [7:0] BLANK = 8'hFF;

  function automatic logic mode_known(input logic [2:0] m);
    return (m == MODE_SIG) || (m == MODE_VERIFY) ||
           (m == MODE_PROG_CODE) || (m == MODE_PROG_KEY);
  endfunction
endpackage

// File: rtl/prom_pulse_gate.sv
module prom_pulse_gate #(
  parameter int PULSES = 5,
  parameter int AW     = 11,
  localparam int CNT_W = $clog2(PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          arm,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  input  logic [2:0]    mode,
  output logic          fire
);
  logic             strobe_q;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    h_addr;
  logic [7:0]       h_data;
  logic [2:0]       h_mode;
  logic             rise, moved;

  assign rise  = strobe && !strobe_q;
  assign moved = (addr != h_addr) || (data != h_data) || (mode != h_mode);
  assign fire  = arm && rise && !moved && (cnt == CNT_W'(PULSES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cnt      <= '0;
      h_addr   <= '0;
      h_data   <= '0;
      h_mode   <= '0;
    end else begin
      strobe_q <= strobe;
      h_addr   <= addr;
      h_data   <= data;
      h_mode   <= mode;
      if (!arm || moved)
        cnt <= (arm && rise) ? CNT_W'(1) : '0;
      else if (rise)
        cnt <= (cnt == CNT_W'(PULSES - 1)) ? '0 : cnt + 1'b1;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PULSES - 1));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && moved && !rise) |=> (cnt == '0));
endmodule

// File: rtl/prom_store.sv
module prom_store #(
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW,
  localparam int KDEPTH = 1 << prom_pkg::KEY_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          wr_code,
  input  logic          wr_key,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    code_q,
  output logic [7:0]    key_q
);
  import prom_pkg::*;
  logic [7:0] code_mem [DEPTH];
  logic [7:0] key_mem  [KDEPTH];

  assign code_q = code_mem[raddr];
  assign key_q  = key_mem[raddr[KEY_AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)  code_mem[i] <= BLANK;
      for (int j = 0; j < KDEPTH; j++) key_mem[j]  <= BLANK;
    end else if (wipe) begin
      for (int i = 0; i < DEPTH; i++)  code_mem[i] <= BLANK;
      for (int j = 0; j < KDEPTH; j++) key_mem[j]  <= BLANK;
    end else begin
      if (wr_code) code_mem[waddr] <= code_mem[waddr] & wdata;
      if (wr_key)  key_mem[waddr[KEY_AW-1:0]] <= key_mem[waddr[KEY_AW-1:0]] & wdata;
    end
  end

  assert_key_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key |-> (waddr[AW-1:KEY_AW] == '0));
  assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_code && !wipe) |=> ((code_mem[$past(waddr)] & ~$past(code_mem[waddr])) == 8'h00));
endmodule

// File: rtl/prom_sig_rom.sv
module prom_sig_rom #(
  parameter int AW = 11,
  parameter logic [7:0] REV = 8'h01
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    sig
);
  always_comb begin
    if (addr == AW'(8'h30) || addr == AW'(8'h31)) sig = 8'h58;
    else if (addr == AW'(8'h60))                 sig = 8'hAD;
    else if (addr == AW'(8'h61))                 sig = REV;
    else                                         sig = 8'hFF;
  end
endmodule

// File: rtl/prom_cipher_port.sv
module prom_cipher_port #(
  parameter int ADDR_W = 11,
  parameter int PULSES = 5,
  parameter logic [7:0] REV = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [2:0]        mode_sel,
  input  logic              prog_strobe,
  input  logic              wipe,
  output logic [7:0]        dout,
  output logic              dout_oe
);
  import prom_pkg::*;

  logic is_pc, is_pk, is_vf, is_sig, key_in_range, arm, fire;
  logic [7:0] code_q, key_q, sig;

  assign is_pc  = (mode_sel == MODE_PROG_CODE);
  assign is_pk  = (mode_sel == MODE_PROG_KEY);
  assign is_vf  = (mode_sel == MODE_VERIFY);
  assign is_sig = (mode_sel == MODE_SIG);
  assign key_in_range = (addr[ADDR_W-1:KEY_AW] == '0);
  assign arm = (is_pc || (is_pk && key_in_range)) && !wipe;

  prom_pulse_gate #(.PULSES(PULSES), .AW(ADDR_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .strobe(prog_strobe), .arm(arm),
    .addr(addr), .data(din), .mode(mode_sel), .fire(fire));

  prom_store #(.AW(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wipe(wipe),
    .wr_code(fire && is_pc), .wr_key(fire && is_pk),
    .waddr(addr), .wdata(din), .raddr(addr),
    .code_q(code_q), .key_q(key_q));

  prom_sig_rom #(.AW(ADDR_W), .REV(REV)) u_sig (.addr(addr), .sig(sig));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= 8'h00;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= is_vf || is_sig;
      if (is_vf)       dout <= ~(code_q ^ key_q);
      else if (is_sig) dout <= sig;
      else             dout <= 8'h00;
    end
  end

  assert_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_known(mode_sel) |=> !dout_oe);
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == 8'h00));
  assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_VERIFY) |=> dout_oe);
endmodule

// File: tb/tb_prom_cipher_port.sv
module tb_prom_cipher_port;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0, prog_strobe = 0, wipe = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic [2:0] mode_sel = 3'b110;
  logic dout_oe;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  prom_cipher_port #(.ADDR_W(AW), .PULSES(5), .REV(8'h07)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode_sel(mode_sel),
    .prog_strobe(prog_strobe), .wipe(wipe), .dout(dout), .dout_oe(dout_oe));

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); mode_sel = m; addr = a; din = d;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); prog_strobe = 1;
      @(negedge clk); prog_strobe = 0;
    end
  endtask

  task automatic rd(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    drive(m, a, 8'h00);
    @(negedge clk);
    chk(req, {dout_oe, dout}, {1'b1, exp});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 in reset", {dout_oe, dout}, 9'h000);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {dout_oe, dout}, 9'h000);
    rd(3'b001, 8'h10, 8'hFF, "R1 blank code");
  endtask

  task automatic t_basic;
    drive(3'b011, 8'h12, 8'hA5); pulses(5);
    rd(3'b001, 8'h12, 8'hA5, "R4 blank key passthrough");
    drive(3'b011, 8'h12, 8'h5A); pulses(5);
    rd(3'b001, 8'h12, 8'h00, "R8 and semantics");
  endtask

  task automatic t_count;
    drive(3'b011, 8'h20, 8'h00); pulses(4);
    rd(3'b001, 8'h20, 8'hFF, "R6 four pulses no commit");
    drive(3'b011, 8'h21, 8'h0F); pulses(3);
    drive(3'b011, 8'h21, 8'hF0); pulses(5);
    rd(3'b001, 8'h21, 8'hF0, "R7 restart on data change");
  endtask

  task automatic t_key;
    drive(3'b111, 8'h05, 8'h3C); pulses(5);
    rd(3'b001, 8'h05, 8'h3C, "R4 code FF returns key");
    rd(3'b001, 8'h45, 8'h3C, "R3 key alias");
    drive(3'b011, 8'h45, 8'h0F); pulses(5);
    rd(3'b001, 8'h45, 8'hCC, "R3 xnor");
    drive(3'b111, 8'h85, 8'h00); pulses(5);
    rd(3'b001, 8'h05, 8'h3C, "R5 out-of-range key ignored");
  endtask

  task automatic t_sig;
    rd(3'b000, 8'h30, 8'h58, "R9 sig 30");
    rd(3'b000, 8'h31, 8'h58, "R9 sig 31");
    rd(3'b000, 8'h60, 8'hAD, "R9 sig 60");
    rd(3'b000, 8'h61, 8'h07, "R9 sig 61");
    rd(3'b000, 8'h32, 8'hFF, "R9 other");
  endtask

  task automatic t_invalid;
    drive(3'b010, 8'h12, 8'h00);
    @(negedge clk);
    chk("R10 invalid 010", {dout_oe, dout}, 9'h000);
    drive(3'b101, 8'h30, 8'h00);
    @(negedge clk);
    chk("R10 invalid 101", {dout_oe, dout}, 9'h000);
    rd(3'b001, 8'h12, 8'h00, "R2 verify re-enables");
  endtask

  task automatic t_wipe;
    @(negedge clk); wipe = 1;
    @(negedge clk); wipe = 0;
    rd(3'b001, 8'h12, 8'hFF, "R11 code wiped");
    rd(3'b001, 8'h45, 8'hFF, "R11 key wiped");
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset; t_basic; t_count; t_key; t_sig; t_invalid; t_wipe;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule